// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This is a purely combinational unit. It takes the opcode of a flow-control instruction and the processor's current status flags, N (negative), Z (zero), C (borrow) and V (overflow), and produces one bit that says whether the branch is taken. Nothing outside that decision is done here. Program-counter update and target fetch belong to the surrounding pipeline.

The unit covers three groups of conditions:

- One branch that is always taken.
- Eight branches that each test a single flag for set or clear.
- Eight relational branches, four signed and four unsigned, for less-than, greater-or-equal, less-or-equal and greater-than.

The relational group assumes the flags were left by a compare. A compare is a subtraction of the operand from the accumulator: C is set on a borrow and V on a two's-complement overflow. Any opcode outside the branch window gives a result of 0.

Top module: `branch_cond_eval`

## Requirements
- R1: Opcode 38h gives taken = 1 for every combination of the four flags.
- R2: Opcode 39h is taken when Z = 1. Opcode 3Ah is taken when Z = 0.
- R3: Opcode 3Bh is taken when N = 1. Opcode 3Ch is taken when N = 0.
- R4: Opcode 3Dh is taken when C = 1. Opcode 3Eh is taken when C = 0.
- R5: Opcode 3Fh is taken when V = 1. Opcode 40h is taken when V = 0.
- R6: Opcode 41h (signed less-than) is taken exactly when N differs from V.
- R7: Opcode 42h (signed greater-or-equal) is taken exactly when N equals V.
- R8: Opcode 43h (signed less-or-equal) is taken when N differs from V or Z = 1. Opcode 44h (signed greater-than) is taken in exactly the opposite case.
- R9: Opcode 45h (unsigned less-than) is taken exactly when C = 1, where C = 1 marks a borrow out of accumulator minus operand.
- R10: Opcode 46h (unsigned greater-or-equal) is taken when C = 0. Opcode 47h (unsigned less-or-equal) is taken when C = 1 or Z = 1. Opcode 48h (unsigned greater-than) is taken when C = 0 and Z = 0.
- R11: Every opcode below 38h or above 48h gives taken = 0, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Opcode of the instruction being evaluated |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag, read as a borrow after a compare |
| flag_v | input | 1 | Two's-complement overflow flag |
| taken | output | 1 | 1 when the branch condition holds |

## Verification
The embedded assertions check the following every time the inputs settle:

- The always-taken opcode.
- The set and clear test on each single flag.
- Each signed and unsigned relation written as a flag formula.
- The zero result outside the branch window.

Those checks cannot show that the flag formulas agree with real comparisons of two numbers. The bench therefore computes N, Z, C and V from actual subtractions of chosen operand pairs and compares each relational branch against the true signed and unsigned order of those pairs. The pairs include the sign-boundary and equal-value cases.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  // Class of condition an opcode asks for
  typedef enum logic [2:0] {
    CK_NONE,
    CK_ALWAYS,
    CK_FLAG,
    CK_SIGNED,
    CK_UNSIGNED
  } cond_kind_e;

  // Decoded condition: flag test fields and relation fields
  typedef struct packed {
    cond_kind_e  kind;
    logic [1:0]  fsel;     // which flag a single-flag test reads
    logic        fneg;     // 1: branch on flag clear
    logic        incl_eq;  // relation also accepts equality
    logic        invert;   // relation is the complement
  } cond_dec_t;

  // Flag positions inside the packed flag vector
  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_V = 3;
  localparam int NUM_FLAGS = 4;

  // After A - B: signed A < B when the sign is wrong because of overflow
  function automatic logic signed_below(input logic n, input logic v);
    return n ^ v;
  endfunction

  // After A - B: unsigned A < B exactly when a borrow occurred
  function automatic logic unsigned_below(input logic c);
    return c;
  endfunction

  // Build lt / ge / le / gt from the "below" term and the zero flag
  function automatic logic apply_rel(input logic below, input logic z,
                                     input logic incl_eq, input logic invert);
    logic r;
    r = below | (incl_eq & z);
    return r ^ invert;
  endfunction

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
#(
  parameter int              OP_W         = 8,
  parameter logic [OP_W-1:0] BASE         = 8'h38,
  parameter int              FLAG_TESTS   = 8,
  parameter int              REL_PER_KIND = 4
) (
  input  logic [OP_W-1:0] opcode,
  output cond_dec_t       dec
);

  localparam int OFF_W      = OP_W + 1;
  localparam int FLAG_FIRST = 1;
  localparam int FLAG_LAST  = FLAG_TESTS;
  localparam int SGN_FIRST  = FLAG_LAST + 1;
  localparam int SGN_LAST   = SGN_FIRST + REL_PER_KIND - 1;
  localparam int UNS_FIRST  = SGN_LAST + 1;
  localparam int UNS_LAST   = UNS_FIRST + REL_PER_KIND - 1;

  logic [OFF_W-1:0] off;
  logic             in_range;
  logic [2:0]       fidx;
  logic [1:0]       sidx;
  logic [1:0]       uidx;

  always_comb begin
    off      = {1'b0, opcode} - {1'b0, BASE};
    in_range = (opcode >= BASE) && (off <= OFF_W'(UNS_LAST));
    fidx     = off[2:0] - 3'(FLAG_FIRST);
    sidx     = off[1:0] - 2'(SGN_FIRST);
    uidx     = off[1:0] - 2'(UNS_FIRST);

    dec.kind    = CK_NONE;
    dec.fsel    = 2'd0;
    dec.fneg    = 1'b0;
    dec.incl_eq = 1'b0;
    dec.invert  = 1'b0;

    if (in_range) begin
      if (off == '0) begin
        dec.kind = CK_ALWAYS;
      end else if (off <= OFF_W'(FLAG_LAST)) begin
        dec.kind = CK_FLAG;
        dec.fsel = fidx[2:1];
        dec.fneg = fidx[0];
      end else if (off <= OFF_W'(SGN_LAST)) begin
        dec.kind    = CK_SIGNED;
        dec.invert  = sidx[0];
        dec.incl_eq = sidx[1];
      end else begin
        dec.kind    = CK_UNSIGNED;
        dec.invert  = uidx[0];
        dec.incl_eq = uidx[1];
      end
    end
  end

  always_comb begin
    // R11
    decode_range_chk: assert ((dec.kind == CK_NONE) ||
                              ((int'(opcode) >= int'(BASE)) &&
                               (int'(opcode) <= int'(BASE) + UNS_LAST)))
      else $error("decode claims a branch outside the window");
  end

endmodule

// File: rtl/bcc_flag_test.sv
module bcc_flag_test
  import bcc_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [1:0]           fsel,
  input  logic                 fneg,
  output logic                 hit
);

  // Two tests per flag: even slot = set, odd slot = clear
  logic [2*NUM_FLAGS-1:0] tests;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      assign tests[2*gi]   = flags[gi];
      assign tests[2*gi+1] = ~flags[gi];
    end
  endgenerate

  assign hit = tests[{fsel, fneg}];

  always_comb begin
    // R2
    zero_test_chk: assert (fsel != 2'(FLAG_Z) || hit == (flags[FLAG_Z] != fneg))
      else $error("zero flag test mismatch");
    // R3
    neg_test_chk: assert (fsel != 2'(FLAG_N) || hit == (flags[FLAG_N] != fneg))
      else $error("negative flag test mismatch");
    // R4
    carry_test_chk: assert (fsel != 2'(FLAG_C) || hit == (flags[FLAG_C] != fneg))
      else $error("carry flag test mismatch");
    // R5
    ovf_test_chk: assert (fsel != 2'(FLAG_V) || hit == (flags[FLAG_V] != fneg))
      else $error("overflow flag test mismatch");
  end

endmodule

// File: rtl/bcc_relation.sv
module bcc_relation
  import bcc_pkg::*;
#(
  parameter bit SIGNED_REL = 1'b1
) (
  input  logic n,
  input  logic z,
  input  logic c,
  input  logic v,
  input  logic incl_eq,
  input  logic invert,
  output logic result
);

  logic below;

  generate
    if (SIGNED_REL) begin : g_signed
      assign below = signed_below(n, v);
      logic unused_c;
      assign unused_c = c;
    end else begin : g_unsigned
      assign below = unsigned_below(c);
      logic unused_nv;
      assign unused_nv = n ^ v;
    end
  endgenerate

  assign result = apply_rel(below, z, incl_eq, invert);

  generate
    if (SIGNED_REL) begin : g_sig_chk
      always_comb begin
        // R6
        slt_chk: assert (incl_eq || invert || result == (n != v))
          else $error("signed less-than mismatch");
        // R7
        sge_chk: assert (incl_eq || !invert || result == (n == v))
          else $error("signed greater-or-equal mismatch");
        // R8
        sle_sgt_chk: assert (!incl_eq || result == (invert ? (n == v && !z) : (n != v || z)))
          else $error("signed le/gt mismatch");
      end
    end else begin : g_uns_chk
      always_comb begin
        // R9
        ult_chk: assert (incl_eq || invert || result == c)
          else $error("unsigned less-than mismatch");
        // R10
        uge_ule_ugt_chk: assert ((!incl_eq && !invert) ||
                                 result == (incl_eq ? ((c || z) != invert) : !c))
          else $error("unsigned ge/le/gt mismatch");
      end
    end
  endgenerate

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bcc_pkg::*;
#(
  parameter int              OP_W         = 8,
  parameter logic [OP_W-1:0] BASE         = 8'h38,
  parameter int              FLAG_TESTS   = 8,
  parameter int              REL_PER_KIND = 4
) (
  input  logic [OP_W-1:0] opcode,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_v,
  output logic            taken
);

  localparam int NUM_BRANCH = 1 + FLAG_TESTS + 2 * REL_PER_KIND;
  localparam int LAST_OP    = int'(BASE) + NUM_BRANCH - 1;

  cond_dec_t            dec;
  logic [NUM_FLAGS-1:0] flags;
  logic                 flag_hit;
  logic                 sgn_hit;
  logic                 uns_hit;

  always_comb begin
    flags         = '0;
    flags[FLAG_Z] = flag_z;
    flags[FLAG_N] = flag_n;
    flags[FLAG_C] = flag_c;
    flags[FLAG_V] = flag_v;
  end

  bcc_decode #(
    .OP_W(OP_W), .BASE(BASE), .FLAG_TESTS(FLAG_TESTS), .REL_PER_KIND(REL_PER_KIND)
  ) u_decode (
    .opcode(opcode),
    .dec   (dec)
  );

  bcc_flag_test u_flag (
    .flags(flags),
    .fsel (dec.fsel),
    .fneg (dec.fneg),
    .hit  (flag_hit)
  );

  bcc_relation #(.SIGNED_REL(1'b1)) u_signed (
    .n(flag_n), .z(flag_z), .c(flag_c), .v(flag_v),
    .incl_eq(dec.incl_eq), .invert(dec.invert),
    .result(sgn_hit)
  );

  bcc_relation #(.SIGNED_REL(1'b0)) u_unsigned (
    .n(flag_n), .z(flag_z), .c(flag_c), .v(flag_v),
    .incl_eq(dec.incl_eq), .invert(dec.invert),
    .result(uns_hit)
  );

  always_comb begin
    unique case (dec.kind)
      CK_ALWAYS:   taken = 1'b1;
      CK_FLAG:     taken = flag_hit;
      CK_SIGNED:   taken = sgn_hit;
      CK_UNSIGNED: taken = uns_hit;
      default:     taken = 1'b0;
    endcase
  end

  always_comb begin
    // R1
    always_taken_chk: assert (opcode != BASE || taken)
      else $error("unconditional branch not taken");
    // R11
    non_branch_chk: assert (!((int'(opcode) < int'(BASE)) || (int'(opcode) > LAST_OP)) || !taken)
      else $error("non-branch opcode reported taken");
  end

endmodule

// File: tb/sim_branch_cond_eval.sv
module sim_branch_cond_eval;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = 8'h00;
  logic       flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic       taken;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  branch_cond_eval u0 (
    .opcode(opcode), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .taken(taken)
  );

  // {opcode, n, z, c, v, expected}
  localparam int NV = 25;
  localparam logic [12:0] VEC [NV] = '{
    {8'h38, 4'b0000, 1'b1}, {8'h38, 4'b1111, 1'b1},
    {8'h39, 4'b0100, 1'b1}, {8'h39, 4'b0000, 1'b0},
    {8'h3A, 4'b0100, 1'b0}, {8'h3A, 4'b0000, 1'b1},
    {8'h3B, 4'b1000, 1'b1}, {8'h3C, 4'b1000, 1'b0},
    {8'h3D, 4'b0010, 1'b1}, {8'h3E, 4'b0010, 1'b0},
    {8'h3F, 4'b0001, 1'b1}, {8'h40, 4'b0001, 1'b0},
    {8'h41, 4'b1000, 1'b1}, {8'h41, 4'b1001, 1'b0},
    {8'h42, 4'b0001, 1'b0}, {8'h43, 4'b0100, 1'b1},
    {8'h44, 4'b0100, 1'b0}, {8'h44, 4'b1001, 1'b1},
    {8'h45, 4'b0010, 1'b1}, {8'h46, 4'b0010, 1'b0},
    {8'h47, 4'b0100, 1'b1}, {8'h48, 4'b0000, 1'b1},
    {8'h37, 4'b1111, 1'b0}, {8'h49, 4'b1111, 1'b0},
    {8'h00, 4'b0000, 1'b0}
  };

  function automatic string req_of(input logic [7:0] op);
    if (op == 8'h38) return "R1";
    if (op == 8'h39 || op == 8'h3A) return "R2";
    if (op == 8'h3B || op == 8'h3C) return "R3";
    if (op == 8'h3D || op == 8'h3E) return "R4";
    if (op == 8'h3F || op == 8'h40) return "R5";
    if (op == 8'h41) return "R6";
    if (op == 8'h42) return "R7";
    if (op == 8'h43 || op == 8'h44) return "R8";
    if (op == 8'h45) return "R9";
    if (op >= 8'h46 && op <= 8'h48) return "R10";
    return "R11";
  endfunction

  // Bench view of single-flag tests: flags given as {n,z,c,v}
  function automatic logic flag_model(input logic [7:0] op, input logic [3:0] f);
    case (op)
      8'h39: return f[2];
      8'h3A: return !f[2];
      8'h3B: return f[3];
      8'h3C: return !f[3];
      8'h3D: return f[1];
      8'h3E: return !f[1];
      8'h3F: return f[0];
      8'h40: return !f[0];
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply_and_check(input logic [7:0] op, input logic [3:0] f,
                                 input logic exp, input string req);
    @(posedge clk);
    opcode = op;
    {flag_n, flag_z, flag_c, flag_v} = f;
    @(negedge clk);
    checks++;
    if (taken !== exp) begin
      errors++;
      $display("FAIL %s op=%02h nzcv=%04b taken=%b expected=%b", req, op, f, taken, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state: idle opcode, clear flags, not taken (R11)
    apply_and_check(8'h00, 4'b0000, 1'b0, "R11");

    // Table walk
    for (int i = 0; i < NV; i++)
      apply_and_check(VEC[i][12:5], VEC[i][4:1], VEC[i][0], req_of(VEC[i][12:5]));

    // R1: always taken for all flags
    for (int f = 0; f < 16; f++)
      apply_and_check(8'h38, 4'(f), 1'b1, "R1");

    // R2..R5: each single-flag test under every flag pattern
    for (int op = 8'h39; op <= 8'h40; op++)
      for (int f = 0; f < 16; f++)
        apply_and_check(8'(op), 4'(f), flag_model(8'(op), 4'(f)), req_of(8'(op)));

    // R6..R10: flags from real subtractions, expected from true order
    begin
      logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h05, 8'h81, 8'h7E};
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          logic [7:0] a, b;
          logic [8:0] d;
          logic [3:0] f;
          logic s_lt, s_eq, u_lt;
          a = vals[ia];
          b = vals[ib];
          d = {1'b0, a} - {1'b0, b};
          f = {d[7], (d[7:0] == 8'h00), d[8], ((a[7] != b[7]) && (d[7] != a[7]))};
          s_lt = ($signed(a) < $signed(b));
          s_eq = (a == b);
          u_lt = (a < b);
          apply_and_check(8'h41, f, s_lt, "R6");
          apply_and_check(8'h42, f, !s_lt, "R7");
          apply_and_check(8'h43, f, s_lt || s_eq, "R8");
          apply_and_check(8'h44, f, !s_lt && !s_eq, "R8");
          apply_and_check(8'h45, f, u_lt, "R9");
          apply_and_check(8'h46, f, !u_lt, "R10");
          apply_and_check(8'h47, f, u_lt || s_eq, "R10");
          apply_and_check(8'h48, f, !u_lt && !s_eq, "R10");
        end
      end
    end

    // R11: every opcode outside the window, flags all set and all clear
    for (int op = 0; op < 256; op++) begin
      if (op < 8'h38 || op > 8'h48) begin
        apply_and_check(8'(op), 4'b1111, 1'b0, "R11");
        apply_and_check(8'(op), 4'b0000, 1'b0, "R11");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule